// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the command-execution core that sits behind the serial shift front end of a serial flash slave. The front end hands it, on each chip-select rising edge, the opcode it collected, the number of whole bytes it shifted in, whether the edge landed on a byte boundary, and the array-relative address. The controller keeps the write-enable latch and the write-in-progress flag. It samples the three block-protect bits from an input and reports them in its status byte. It executes sector, block and whole-array erase commands against a small register-based memory array.

An erase is accepted only when the write-enable latch is set, the frame is exactly the right length, and the target is not locked. An accepted erase starts a self-timed busy period whose length is a parameter for each erase size. While the period runs, only status reads have any meaning, and the status byte shows the busy flag. When the period ends, every word of the selected region becomes all ones, and both status flags drop. A refused erase also drops the write-enable latch, so the host must write-enable again before it retries.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Opcode 0x06, framed as exactly one byte with a boundary-aligned chip-select rise, sets the write-enable latch (status bit 1) while idle.
- R2: An erase opcode (0x20 sector, 0xD8 block, 0x60 or 0xC7 whole array) received while the write-enable latch is clear changes nothing. Busy stays 0 and the memory is untouched.
- R3: An erase whose chip-select rise is not boundary-aligned, or whose byte count is wrong (four for sector and block, one for whole array), is not executed and clears the write-enable latch.
- R4: An accepted erase raises busy (status bit 0) on the clock edge that samples the chip-select rise. Busy stays high for exactly SE_CYCLES, BE_CYCLES or CE_CYCLES clocks, depending on the erase size.
- R5: At the end of the busy period, busy and the write-enable latch both return to 0. The latch remains set throughout the period.
- R6: A sector erase sets to all ones every word of the sector that contains the given address, and no other word.
- R7: A block erase sets to all ones every word of the block that contains the given address, and no other word.
- R8: A whole-array erase sets every word of the array to all ones.
- R9: The protect level P (status bits 4:2) locks the top min(2^(P-1), NUM_BLOCKS) blocks when P is not 0. A sector or block erase aimed at a locked block is not executed and clears the latch. Erases aimed at unlocked blocks proceed.
- R10: A whole-array erase runs only when the protect level is 0. Otherwise it is refused and clears the latch.
- R11: While busy, every command other than status read is ignored. Write-enable has no effect, and a second erase neither extends nor restarts the busy period.
- R12: After reset, the status byte reads the protect level with both flags 0, and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_rise_i | input | 1 | One-cycle pulse: chip select has just risen, ending a command |
| cs_aligned_i | input | 1 | The rise fell exactly after a whole byte |
| byte_cnt_i | input | 3 | Whole bytes shifted in, opcode included |
| opcode_i | input | 8 | First byte of the command |
| addr_i | input | MEM_AW | Array-relative word address from the address bytes |
| bp_i | input | 3 | Block-protect level |
| status_o | output | 8 | {3'b0, protect level, write-enable latch, busy} |
| rd_addr_i | input | MEM_AW | Array read address |
| rd_data_o | output | DATA_W | Array word at rd_addr_i |

## Verification
On every cycle, the bound checker confirms several properties. The latch can rise only from a write-enable while idle. Busy can start only from a chip-select rise that found the latch set. Busy always ends with the latch clear. Commands that lack the latch or that are misaligned never start busy, and a whole-array erase under any protect level never starts busy. Other behaviour needs the bench's scenarios. These are the exact length of each busy period, which words a sector, block or whole-array erase reaches, the protection map on particular blocks, and the fact that commands issued mid-erase leave no trace once the period ends.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_SEC_ER  = 8'h20;
    localparam logic [7:0] OP_BLK_ER  = 8'hD8;
    localparam logic [7:0] OP_ALL_ER1 = 8'h60;
    localparam logic [7:0] OP_ALL_ER2 = 8'hC7;

    localparam logic [2:0] LEN_SHORT  = 3'd1;
    localparam logic [2:0] LEN_ADDR   = 3'd4;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WR_EN,
        CMD_RD_STAT,
        CMD_SEC,
        CMD_BLK,
        CMD_ALL
    } cmd_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } ctl_state_e;

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import flash_erase_pkg::*;
(
    input  logic [7:0] opcode_i,
    input  logic [2:0] byte_cnt_i,
    input  logic       aligned_i,
    output cmd_kind_e  kind_o,
    output logic       frame_ok_o
);

    logic [2:0] need_len;

    always_comb begin
        kind_o   = CMD_NONE;
        need_len = LEN_SHORT;
        unique case (opcode_i)
            OP_WR_EN:   kind_o = CMD_WR_EN;
            OP_RD_STAT: kind_o = CMD_RD_STAT;
            OP_SEC_ER: begin
                kind_o   = CMD_SEC;
                need_len = LEN_ADDR;
            end
            OP_BLK_ER: begin
                kind_o   = CMD_BLK;
                need_len = LEN_ADDR;
            end
            OP_ALL_ER1, OP_ALL_ER2: kind_o = CMD_ALL;
            default:    kind_o = CMD_NONE;
        endcase
        if (kind_o == CMD_RD_STAT) begin
            frame_ok_o = 1'b1;
        end else begin
            frame_ok_o = aligned_i && (byte_cnt_i == need_len);
        end
    end

endmodule

// File: rtl/fe_protect.sv
module fe_protect #(
    parameter int NUM_BLOCKS = 4,
    parameter int BLK_W      = 2
) (
    input  logic [2:0]       bp_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             blk_locked_o,
    output logic             any_locked_o
);

    logic [31:0] lock_cnt;

    always_comb begin
        lock_cnt = 32'd0;
        if (bp_i != 3'd0) begin
            lock_cnt = 32'd1 << (bp_i - 3'd1);
            if (lock_cnt > 32'(NUM_BLOCKS)) begin
                lock_cnt = 32'(NUM_BLOCKS);
            end
        end
        blk_locked_o = (32'(blk_i) + lock_cnt) >= 32'(NUM_BLOCKS);
        any_locked_o = (bp_i != 3'd0);
    end

endmodule

// File: rtl/fe_busy_timer.sv
module fe_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = tmr_q.run && (tmr_q.cnt == '0);
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = load_val_i;
        end else if (done_o) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/fe_erase_array.sv
module fe_erase_array #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic [AW-1:0]     lo_i,
    input  logic [AW-1:0]     hi_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        always_comb begin
            mem_d[gi] = mem_q[gi];
            if (erase_i && (AW'(gi) >= lo_i) && (AW'(gi) <= hi_i)) begin
                mem_d[gi] = '1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else begin
                mem_q[gi] <= mem_d[gi];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int DATA_W            = 8,
    parameter int WORDS_PER_SECTOR  = 4,
    parameter int SECTORS_PER_BLOCK = 2,
    parameter int NUM_BLOCKS        = 4,
    parameter int SE_CYCLES         = 16,
    parameter int BE_CYCLES         = 32,
    parameter int CE_CYCLES         = 64,
    parameter int MEM_AW            = $clog2(WORDS_PER_SECTOR * SECTORS_PER_BLOCK * NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise_i,
    input  logic              cs_aligned_i,
    input  logic [2:0]        byte_cnt_i,
    input  logic [7:0]        opcode_i,
    input  logic [MEM_AW-1:0] addr_i,
    input  logic [2:0]        bp_i,
    output logic [7:0]        status_o,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int WORDS     = WORDS_PER_SECTOR * SECTORS_PER_BLOCK * NUM_BLOCKS;
    localparam int SEC_LOW   = $clog2(WORDS_PER_SECTOR);
    localparam int BLK_LOW   = $clog2(WORDS_PER_SECTOR * SECTORS_PER_BLOCK);
    localparam int BLK_W     = MEM_AW - BLK_LOW;
    localparam int MAX_CYC   = (CE_CYCLES > BE_CYCLES) ?
                               ((CE_CYCLES > SE_CYCLES) ? CE_CYCLES : SE_CYCLES) :
                               ((BE_CYCLES > SE_CYCLES) ? BE_CYCLES : SE_CYCLES);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [MEM_AW-1:0] SEC_MASK = MEM_AW'((1 << SEC_LOW) - 1);
    localparam logic [MEM_AW-1:0] BLK_MASK = MEM_AW'((1 << BLK_LOW) - 1);

    typedef struct packed {
        ctl_state_e        state;
        logic              wel;
        logic [MEM_AW-1:0] lo;
        logic [MEM_AW-1:0] hi;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    cmd_kind_e         kind;
    logic              frame_ok;
    logic              blk_locked;
    logic              any_locked;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              erase_go;
    logic              target_locked;

    fe_cmd_decode u_dec (
        .opcode_i   (opcode_i),
        .byte_cnt_i (byte_cnt_i),
        .aligned_i  (cs_aligned_i),
        .kind_o     (kind),
        .frame_ok_o (frame_ok)
    );

    fe_protect #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_prot (
        .bp_i         (bp_i),
        .blk_i        (addr_i[MEM_AW-1:BLK_LOW]),
        .blk_locked_o (blk_locked),
        .any_locked_o (any_locked)
    );

    fe_busy_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    fe_erase_array #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .AW     (MEM_AW)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_i   (erase_go),
        .lo_i      (ctl_q.lo),
        .hi_i      (ctl_q.hi),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        ctl_d         = ctl_q;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        erase_go      = 1'b0;
        target_locked = (kind == CMD_ALL) ? any_locked : blk_locked;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cs_rise_i) begin
                    unique case (kind)
                        CMD_WR_EN: begin
                            if (frame_ok) begin
                                ctl_d.wel = 1'b1;
                            end
                        end
                        CMD_SEC, CMD_BLK, CMD_ALL: begin
                            if (ctl_q.wel) begin
                                if (!frame_ok || target_locked) begin
                                    ctl_d.wel = 1'b0;
                                end else begin
                                    ctl_d.state = ST_BUSY;
                                    tmr_load    = 1'b1;
                                    if (kind == CMD_SEC) begin
                                        tmr_val  = CNT_W'(SE_CYCLES - 1);
                                        ctl_d.lo = addr_i & ~SEC_MASK;
                                        ctl_d.hi = addr_i | SEC_MASK;
                                    end else if (kind == CMD_BLK) begin
                                        tmr_val  = CNT_W'(BE_CYCLES - 1);
                                        ctl_d.lo = addr_i & ~BLK_MASK;
                                        ctl_d.hi = addr_i | BLK_MASK;
                                    end else begin
                                        tmr_val  = CNT_W'(CE_CYCLES - 1);
                                        ctl_d.lo = '0;
                                        ctl_d.hi = MEM_AW'(WORDS - 1);
                                    end
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.wel   = 1'b0;
                    erase_go    = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, wel: 1'b0, lo: '0, hi: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status_o = {3'b000, bp_i, ctl_q.wel, (ctl_q.state == ST_BUSY)};

endmodule

// File: rtl/fe_erase_checker.sv
module fe_erase_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_rise,
    input logic       aligned,
    input logic [7:0] opcode,
    input logic [2:0] bp,
    input logic [7:0] status
);

    logic wip;
    logic wel;
    assign wip = status[0];
    assign wel = status[1];

    p_wel_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise && (opcode == 8'h06)));

    p_no_latch_no_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !wel && !wip) |=> !wip);

    p_misaligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !aligned && !wip) |=> !wip);

    p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise && wel));

    p_latch_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> wel);

    p_end_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    p_all_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !wip && ((opcode == 8'h60) || (opcode == 8'hC7)) && (bp != 3'd0)) |=> !wip);

    p_busy_no_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(!wip));

endmodule

bind flash_erase_ctrl fe_erase_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_rise (cs_rise_i),
    .aligned (cs_aligned_i),
    .opcode  (opcode_i),
    .bp      (bp_i),
    .status  (status_o)
);

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/100ps
module flash_erase_ctrl_test;

    localparam int SE_N = 16;
    localparam int BE_N = 32;
    localparam int CE_N = 64;
    localparam int AW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_rise = 1'b0;
    logic          cs_aligned = 1'b0;
    logic [2:0]    byte_cnt = '0;
    logic [7:0]    opcode = '0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    bp = '0;
    logic [7:0]    status;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    typedef struct {
        bit         is_mem;
        int         where;
        logic [7:0] want;
        string      tag;
    } item_t;

    item_t q[$];
    int    pending = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    flash_erase_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_rise_i    (cs_rise),
        .cs_aligned_i (cs_aligned),
        .byte_cnt_i   (byte_cnt),
        .opcode_i     (opcode),
        .addr_i       (addr),
        .bp_i         (bp),
        .status_o     (status),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            item_t it;
            logic [7:0] got;
            wait (q.size() > 0);
            it = q.pop_front();
            if (it.is_mem) begin
                rd_addr = AW'(it.where);
                #0.5;
                got = rd_data;
            end else begin
                got = status;
            end
            checks++;
            if (got !== it.want) begin
                fails++;
                $display("FAIL %s: got %02h expected %02h (item %0d)", it.tag, got, it.want, it.where);
            end
            pending--;
        end
    end

    function automatic logic [7:0] st(input logic wel, input logic wip);
        return {3'b000, bp, wel, wip};
    endfunction

    task automatic flush();
        wait (pending == 0);
    endtask

    task automatic exp_status(input string tag, input logic wel, input logic wip);
        item_t it;
        it.is_mem = 1'b0; it.where = -1; it.want = st(wel, wip); it.tag = tag;
        pending++;
        q.push_back(it);
        flush();
    endtask

    task automatic exp_mem(input string tag, input int a, input logic [7:0] v);
        item_t it;
        it.is_mem = 1'b1; it.where = a; it.want = v; it.tag = tag;
        pending++;
        q.push_back(it);
        flush();
    endtask

    task automatic send(input logic [7:0] op, input logic [2:0] cnt,
                        input logic al, input logic [AW-1:0] a);
        @(negedge clk);
        opcode = op; byte_cnt = cnt; cs_aligned = al; addr = a; cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0; cs_aligned = 1'b0; byte_cnt = '0;
    endtask

    task automatic wren();
        send(8'h06, 3'd1, 1'b1, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full accepted erase with busy-window checks (R4, R5)
    task automatic run_erase(input logic [7:0] op, input logic [2:0] cnt,
                             input logic [AW-1:0] a, input int n, input string tag);
        wren();
        send(op, cnt, 1'b1, a);
        exp_status({tag, " R4 busy at start"}, 1'b1, 1'b1);
        idle(n - 1);
        exp_status({tag, " R4 busy last cycle"}, 1'b1, 1'b1);
        idle(1);
        exp_status({tag, " R5 end clears flags"}, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        exp_status("R12 status after reset", 1'b0, 1'b0);
        exp_mem("R12 word 0 after reset", 0, 8'h00);
        exp_mem("R12 word 31 after reset", 31, 8'h00);

        // R2 erase without latch
        send(8'h20, 3'd4, 1'b1, 5'd5);
        exp_status("R2 no busy without latch", 1'b0, 1'b0);
        idle(SE_N + 2);
        exp_mem("R2 memory untouched", 5, 8'h00);

        // R1 write enable, wrong length first
        send(8'h06, 3'd2, 1'b1, '0);
        exp_status("R1 over-long write enable ignored", 1'b0, 1'b0);
        wren();
        exp_status("R1 latch set", 1'b1, 1'b0);

        // R3 misaligned erase rejected, latch cleared
        send(8'h20, 3'd4, 1'b0, 5'd5);
        exp_status("R3 misaligned rejected", 1'b0, 1'b0);
        wren();
        send(8'h20, 3'd3, 1'b1, 5'd5);
        exp_status("R3 short frame rejected", 1'b0, 1'b0);
        idle(SE_N + 2);
        exp_mem("R3 memory untouched", 5, 8'h00);

        // R6 sector erase from a middle address
        run_erase(8'h20, 3'd4, 5'd6, SE_N, "R6 sector");
        exp_mem("R6 sector first word", 4, 8'hFF);
        exp_mem("R6 sector last word", 7, 8'hFF);
        exp_mem("R6 word below sector", 3, 8'h00);
        exp_mem("R6 word above sector", 8, 8'h00);

        // R7 block erase, with commands issued while busy (R11)
        wren();
        send(8'hD8, 3'd4, 1'b1, 5'd10);
        exp_status("R7 R4 block busy at start", 1'b1, 1'b1);
        wren();
        send(8'h20, 3'd4, 1'b1, 5'd17);
        exp_status("R11 still busy after extra commands", 1'b1, 1'b1);
        idle(BE_N - 1 - 4);
        exp_status("R4 block busy last cycle", 1'b1, 1'b1);
        idle(1);
        exp_status("R5 block end clears flags", 1'b0, 1'b0);
        idle(SE_N + 2);
        exp_status("R11 no second busy period", 1'b0, 1'b0);
        exp_mem("R7 block first word", 8, 8'hFF);
        exp_mem("R7 block last word", 15, 8'hFF);
        exp_mem("R7 word above block", 16, 8'h00);
        exp_mem("R11 erase during busy dropped", 17, 8'h00);

        // R9 protect level 1 locks the top block (words 24..31)
        bp = 3'd1;
        wren();
        send(8'h20, 3'd4, 1'b1, 5'd26);
        exp_status("R9 locked sector refused", 1'b0, 1'b0);
        idle(SE_N + 2);
        exp_mem("R9 locked sector untouched", 26, 8'h00);

        // R10 whole-array erase refused under protection
        wren();
        send(8'hC7, 3'd1, 1'b1, '0);
        exp_status("R10 array erase refused", 1'b0, 1'b0);
        idle(CE_N + 2);
        exp_mem("R10 memory untouched", 16, 8'h00);

        // R9 unlocked block still erasable
        run_erase(8'h20, 3'd4, 5'd17, SE_N, "R9 unlocked sector");
        exp_mem("R9 unlocked sector erased", 16, 8'hFF);
        exp_mem("R9 neighbour sector kept", 20, 8'h00);

        // R9 level 2 locks two blocks (words 16..31)
        bp = 3'd2;
        wren();
        send(8'hD8, 3'd4, 1'b1, 5'd20);
        exp_status("R9 level 2 block refused", 1'b0, 1'b0);
        idle(BE_N + 2);
        exp_mem("R9 level 2 block untouched", 21, 8'h00);

        // R8 whole-array erase with protection off
        bp = 3'd0;
        run_erase(8'h60, 3'd1, 5'd0, CE_N, "R8 array");
        exp_mem("R8 word 0", 0, 8'hFF);
        exp_mem("R8 word 20", 20, 8'hFF);
        exp_mem("R8 word 31", 31, 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule